// File: doc/BRIEF.md
# External Interrupt Line Controller

This block conditions four external interrupt pins before they reach an interrupt priority encoder. Each pin is first brought into the clock domain through a synchroniser. It is then qualified by a per-line trigger mode. Two of the modes are level modes, active high or active low, where the request follows the pin. The other two are edge modes, rising or falling, where a detected edge sets a sticky pending bit. That bit stays set until software clears it.

A single 32-bit control word holds all of the configuration. It contains a 2-bit trigger code for each line, an enable bit for each line, a master enable and a critical-routing select. The same word also carries write-one-to-clear bits for the pending edges. Line 0 produces the critical-group request. Lines 1 to 3 produce the main-group requests for sources 1 to 3.

The bit positions in the control word are fixed. For enable, trigger code and clear, line 0 always occupies the highest-numbered slot of its field, and the higher lines sit in descending order below it.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0, and `crit_req` and `main_req` are all low.
- R2: The writable bits are the trigger codes (bits 23..16), the master enable (bit 12), the line enables (bits 11..8) and the route select (bit 0). These read back as written. Every other bit, including the clear bits 27..24, reads 0. Writing all ones reads back 0x00FF1F01.
- R3: The trigger code of line n sits at bits [23-2n:22-2n], and the enable of line n sits at bit 11-n. Each line reacts only to its own fields.
- R4: With code 0 (active high), a line's request equals its pin as seen after two rising clock edges of synchronisation.
- R5: With code 3 (active low), a line's request is the inverse of the synchronised pin.
- R6: With code 1 (rising edge), a 0-to-1 change of the synchronised pin sets the pending bit. A pin change made before edge k shows on the request after edge k+2. The pending bit stays set while the pin later falls.
- R7: With code 2 (falling edge), a 1-to-0 change of the synchronised pin sets the pending bit, with the same timing as R6.
- R8: A write with bit 27-n set clears the pending bit of line n only, taking effect at that write's clock edge.
- R9: When a clear write and a new edge on the same line land on the same clock edge, the pending bit stays set.
- R10: A request is asserted only when its line enable and the master enable are both 1. An edge latched while either enable is 0 stays pending and raises the request as soon as both are 1.
- R11: `crit_req` comes from line 0, and `main_req[k-1]` comes from line k. `crit_route_normal` equals bit 0 of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| irq_pin | input | 4 | Asynchronous external interrupt pins, bit n is line n |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| crit_req | output | 1 | Critical-group request from line 0 |
| main_req | output | 3 | Main-group requests, bit k-1 from line k |
| crit_route_normal | output | 1 | Critical routing select, bit 0 of the control word |

## Verification
The checker assumes that `rst_n` is released in step with the clock. It also assumes that the pins, although asynchronous in a real system, are given one value per cycle, so that the synchroniser output is a delayed copy of the pin. The bench drives the pins and the write port only on the falling clock edge, so every value is settled at the rising edge. The checker's sticky-pending property assumes that nothing other than a control write can remove a pending edge. The bench's random writes therefore set clear bits only through `cfg_wr`, and the stimulus includes write cycles that carry no clear bits.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int LINES      = 4;
  localparam int WORD_W     = 32;
  localparam int MASTER_BIT = 12;
  localparam int ROUTE_BIT  = 0;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_LOW  = 2'd3
  } trig_e;

  function automatic int trig_lsb(input int n);
    return 22 - 2 * n;
  endfunction

  function automatic int enable_pos(input int n);
    return 11 - n;
  endfunction

  function automatic int clear_pos(input int n);
    return 27 - n;
  endfunction

  function automatic logic [WORD_W-1:0] writable_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int n = 0; n < LINES; n++) begin
      m[trig_lsb(n)]     = 1'b1;
      m[trig_lsb(n) + 1] = 1'b1;
      m[enable_pos(n)]   = 1'b1;
    end
    m[MASTER_BIT] = 1'b1;
    m[ROUTE_BIT]  = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] CTRL_WMASK = writable_mask();

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int LINES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_i,
  output logic [LINES-1:0] sync_o
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], pin_i[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= stg_d;
    end

    assign sync_o[i] = stg_q[STAGES-1];
  end

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int NLINES = LINES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic [WORD_W-1:0]      wdata_i,
  output logic [WORD_W-1:0]      rdata_o,
  output logic [NLINES-1:0][1:0] trig_o,
  output logic [NLINES-1:0]      en_o,
  output logic [NLINES-1:0]      clr_o,
  output logic                   master_o,
  output logic                   route_o
);

  logic [WORD_W-1:0] ctrl_q;
  logic [WORD_W-1:0] ctrl_d;
  logic              ctrl_ce;

  assign ctrl_ce = wr_i;

  always_comb begin
    ctrl_d = wdata_i & CTRL_WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  for (genvar n = 0; n < NLINES; n++) begin : g_fld
    assign trig_o[n] = ctrl_q[trig_lsb(n) +: 2];
    assign en_o[n]   = ctrl_q[enable_pos(n)];
    assign clr_o[n]  = wr_i & wdata_i[clear_pos(n)];
  end

  assign master_o = ctrl_q[MASTER_BIT];
  assign route_o  = ctrl_q[ROUTE_BIT];
  assign rdata_o  = ctrl_q;

endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  logic [1:0] trig_i,
  input  logic       en_i,
  input  logic       master_i,
  input  logic       clr_i,
  output logic       pend_o,
  output logic       req_o
);

  logic prev_q;
  logic pend_q;
  logic pend_d;
  logic edge_mode;
  logic hit;
  logic level_act;
  logic cond;

  always_comb begin
    edge_mode = trig_i[0] ^ trig_i[1];
    hit       = 1'b0;
    if (trig_i == TRIG_RISE) hit = sync_i & ~prev_q;
    if (trig_i == TRIG_FALL) hit = ~sync_i & prev_q;
    pend_d    = hit | (pend_q & ~clr_i);
    level_act = sync_i ^ (trig_i == TRIG_LOW);
    cond      = edge_mode ? pend_q : level_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
  assign req_o  = cond & en_i & master_i;

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  irq_pin,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        crit_req,
  output logic [2:0]  main_req,
  output logic        crit_route_normal
);

  logic [LINES-1:0]      sync_w;
  logic [LINES-1:0][1:0] trig_w;
  logic [LINES-1:0]      en_w;
  logic [LINES-1:0]      clr_w;
  logic [LINES-1:0]      pend_w;
  logic [LINES-1:0]      req_w;
  logic                  master_w;

  ext_irq_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (irq_pin),
    .sync_o (sync_w)
  );

  ext_irq_regs #(.NLINES(LINES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cfg_wr),
    .wdata_i  (cfg_wdata),
    .rdata_o  (cfg_rdata),
    .trig_o   (trig_w),
    .en_o     (en_w),
    .clr_o    (clr_w),
    .master_o (master_w),
    .route_o  (crit_route_normal)
  );

  for (genvar n = 0; n < LINES; n++) begin : g_ln
    ext_irq_line u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (sync_w[n]),
      .trig_i   (trig_w[n]),
      .en_i     (en_w[n]),
      .master_i (master_w),
      .clr_i    (clr_w[n]),
      .pend_o   (pend_w[n]),
      .req_o    (req_w[n])
    );
  end

  assign crit_req = req_w[0];
  assign main_req = req_w[LINES-1:1];

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [31:0] cfg_rdata,
  input logic        crit_req,
  input logic [2:0]  main_req,
  input logic [3:0]  pend,
  input logic [3:0]  sync
);

  a_r10_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[12] |-> (!crit_req && main_req == 3'b000));

  a_r2_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[27:24] == 4'b0000);

  a_r4_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[23:22] == 2'd0 && cfg_rdata[11] && cfg_rdata[12]) |-> (crit_req == sync[0]));

  for (genvar i = 0; i < 4; i++) begin : g_st
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !cfg_wr) |=> pend[i]);
  end

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_rdata (cfg_rdata),
  .crit_req  (crit_req),
  .main_req  (main_req),
  .pend      (pend_w),
  .sync      (sync_w)
);

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq_pin = '0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        crit_req;
  logic [2:0]  main_req;
  logic        crit_route_normal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl uut (
    .clk               (clk),
    .rst_n             (rst_n),
    .irq_pin           (irq_pin),
    .cfg_wr            (cfg_wr),
    .cfg_wdata         (cfg_wdata),
    .cfg_rdata         (cfg_rdata),
    .crit_req          (crit_req),
    .main_req          (main_req),
    .crit_route_normal (crit_route_normal)
  );

  // Reference state built from the requirements
  localparam logic [31:0] WMASK = 32'h00FF_1F01;
  logic [31:0] m_ctrl;
  logic [3:0]  m_s1, m_s2, m_prev, m_pend;

  function automatic logic [1:0] m_trig(input logic [31:0] c, input int n);
    return c[22-2*n +: 2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0;
    end else begin
      for (int n = 0; n < 4; n++) begin
        logic hit;
        logic [1:0] t;
        t = m_trig(m_ctrl, n);
        hit = (t == 2'd1 && m_s2[n] && !m_prev[n]) || (t == 2'd2 && !m_s2[n] && m_prev[n]);
        m_pend[n] <= hit || (m_pend[n] && !(cfg_wr && cfg_wdata[27-n]));
      end
      m_s1   <= irq_pin;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      if (cfg_wr) m_ctrl <= cfg_wdata & WMASK;
    end
  end

  function automatic logic exp_req(input int n);
    logic [1:0] t;
    logic c;
    t = m_trig(m_ctrl, n);
    case (t)
      2'd0: c = m_s2[n];
      2'd3: c = !m_s2[n];
      default: c = m_pend[n];
    endcase
    return c && m_ctrl[11-n] && m_ctrl[12];
  endfunction

  function automatic string mode_tag(input int n);
    case (m_trig(m_ctrl, n))
      2'd0: return "R4";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2", cfg_rdata, m_ctrl);
    chk("R11", {31'd0, crit_route_normal}, {31'd0, m_ctrl[0]});
    chk({mode_tag(0), " line0 R11"}, {31'd0, crit_req}, {31'd0, exp_req(0)});
    for (int k = 1; k < 4; k++)
      chk({mode_tag(k), " R3"}, {31'd0, main_req[k-1]}, {31'd0, exp_req(k)});
  endtask

  task automatic cyc(input logic [3:0] p, input logic w, input logic [31:0] d);
    irq_pin = p; cfg_wr = w; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdata", cfg_rdata, 32'h0);
    chk("R1 req", {28'd0, main_req, crit_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: writable bits read back; clear bits read 0
    cyc(4'h0, 1'b1, 32'hFFFF_FFFF);
    chk("R2 all ones", cfg_rdata, 32'h00FF_1F01);
    cyc(4'h0, 1'b1, 32'h0F00_0000);
    chk("R2 clear bits read 0", cfg_rdata, 32'h0);

    // R9 then R8 on line 2, rising edge: code 1 at bit 18, enable bit 9, master, route
    cyc(4'h0, 1'b1, 32'h0004_1201);
    cyc(4'h4, 1'b0, 32'h0);
    cyc(4'h4, 1'b0, 32'h0);
    cyc(4'h4, 1'b1, 32'h0204_1201);
    chk("R9 collision keeps pending", {29'd0, main_req}, 32'h2);
    cyc(4'h0, 1'b0, 32'h0);
    chk("R6 sticky after pin falls", {29'd0, main_req}, 32'h2);
    cyc(4'h0, 1'b1, 32'h0104_1201);
    chk("R8 other clear bit ignored", {29'd0, main_req}, 32'h2);
    cyc(4'h0, 1'b1, 32'h0204_1201);
    chk("R8 own clear", {29'd0, main_req}, 32'h0);

    // R10: line 1 rising (bit 20), enable bit 10, master off while edge arrives
    cyc(4'h0, 1'b1, 32'h0010_0400);
    for (int i = 0; i < 4; i++) cyc(4'h2, 1'b0, 32'h0);
    chk("R10 masked by master", {29'd0, main_req}, 32'h0);
    cyc(4'h2, 1'b1, 32'h0010_1400);
    chk("R10 pending shows on enable", {29'd0, main_req}, 32'h1);

    // R5: line 0 active low (bits 23:22 = 3), enable bit 11
    cyc(4'h0, 1'b1, 32'h00C0_1800);
    cyc(4'h0, 1'b0, 32'h0);
    chk("R5 low level asserts", {31'd0, crit_req}, 32'h1);
    cyc(4'h1, 1'b0, 32'h0);
    chk("R5 one edge later still old", {31'd0, crit_req}, 32'h1);
    cyc(4'h1, 1'b0, 32'h0);
    chk("R5 deasserts after sync", {31'd0, crit_req}, 32'h0);

    // Random phase covering R3..R9
    for (int i = 0; i < 6000; i++) begin
      logic [3:0] p;
      logic w;
      logic [31:0] d;
      p = irq_pin;
      for (int n = 0; n < 4; n++) if ($urandom_range(3) == 0) p[n] = ~p[n];
      w = ($urandom_range(7) == 0);
      d = $urandom;
      if ($urandom_range(3) != 0) d[12] = 1'b1;
      if ($urandom_range(1) == 0) d[27:24] = 4'h0;
      cyc(p, w, d);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule